// File: doc/BRIEF.md
# Time-Code Master/Slave Controller

This block keeps an 8-bit time-code register for a packet switch and decides when a time-code goes out to the network ports. The upper two bits are control bits that pass through unchanged. The lower six bits count modulo 64. The block has two modes. In master mode, each rising edge of an external tick input makes the block send a code to every port. In slave mode, the block checks codes received from the link ports and forwards only those that continue the sequence.

In master mode the code sent is either the register advanced by one or, if the load-select pin is high at that tick, the external 8-bit value. In slave mode every received code is written into the register. The code is forwarded only when it equals the old register value plus one. It then goes to every port except the one it arrived on, and a stretched external tick-out pulse carries it to the host. Codes that circle round a loop in the network therefore stop after one pass. Link-level character coding is not part of this block.

Top module: `time_code_ctrl`

## Requirements
- R1: After reset, no transmit strobe is raised, the external tick-out is low, the external time output is 0 and the register holds 0.
- R2: In master mode with the load-select pin low, a rising edge on the external tick makes the block send {reg[7:6], reg[5:0]+1} on all ports. The transmit strobes are high for one cycle, SYNC_STAGES+1 clock edges after the input edge.
- R3: The low six bits wrap from 63 to 0 and the upper two bits stay the same. For example, 0xBF advances to 0x80.
- R4: In master mode, if the load-select pin is high at the detected tick edge, the external value is loaded and sent unchanged.
- R5: One rising edge of the external tick gives exactly one send, however long the input stays high.
- R6: The clear input sets the register to 0 and suppresses any send in that cycle. The next automatic send is 0x01.
- R7: In slave mode, a received code equal to {reg[7:6], reg[5:0]+1} is sent one cycle after its strobe. It goes to every port except the arrival port (bit i of the strobe vector is port i).
- R8: A forwarded code raises the external tick-out one cycle after reception. The tick-out stays high for TICK_HOLD cycles and then falls. The external time output holds the code while the tick-out is high.
- R9: In slave mode, a received code that does not continue the sequence produces no transmit strobe and no tick-out, but the register is still loaded with it.
- R10: When several ports strobe in the same cycle, only the lowest-numbered port is taken and the others are dropped.
- R11: Received codes are ignored in master mode, and the external tick is ignored in slave mode. The register and the outputs are left untouched in both cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_tick_i | input | 1 | Asynchronous external tick; its rising edge triggers a master send |
| ext_value_i | input | 8 | External code value |
| ext_load_i | input | 1 | Load-select: use ext_value_i instead of advancing |
| clr_count_i | input | 1 | Clears the time-code register |
| master_mode_i | input | 1 | 1 = master, 0 = slave |
| rx_valid_i | input | NUM_PORTS | Per-port received-code strobe |
| rx_code_i | input | 8*NUM_PORTS | Received codes, port i at bits [8i+7:8i] |
| tx_valid_o | output | NUM_PORTS | Per-port transmit strobe |
| tx_code_o | output | 8 | Code to transmit |
| ext_tick_o | output | 1 | Stretched tick-out; its falling edge ends the pulse |
| ext_time_o | output | 8 | Code that goes with the tick-out |

## Verification
A master send is due SYNC_STAGES+1 clock edges after the external tick is driven: the synchronizer stages, then the output register. A slave forward, and the first cycle of the tick-out, are due one edge after the receive strobe. The tick-out then stays high for exactly TICK_HOLD sampled cycles. The bench drives inputs on the falling clock edge. It counts falling edges so that each sample lands at exactly those cycle counts. Around each event it also checks the cycles just before and just after, to catch strobes that come early, come late or repeat.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int TC_W  = 8;
  localparam int CNT_W = 6;

  typedef logic [TC_W-1:0] tcode_t;

  function automatic tcode_t tc_advance(input tcode_t c);
    return {c[TC_W-1:CNT_W], c[CNT_W-1:0] + {{(CNT_W-1){1'b0}}, 1'b1}};
  endfunction
endpackage

// File: rtl/tc_edge_sync.sv
module tc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-1:0], async_i};
  end

  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/tc_rx_pick.sv
module tc_rx_pick
  import tc_pkg::*;
#(
  parameter int PORTS = 4,
  parameter int IDX_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PORTS-1:0]      rx_valid_i,
  input  logic [PORTS*TC_W-1:0] rx_code_i,
  output logic                  any_o,
  output logic [IDX_W-1:0]      idx_o,
  output tcode_t                code_o
);
  tcode_t codes [PORTS];

  for (genvar g = 0; g < PORTS; g++) begin : g_unpack
    assign codes[g] = rx_code_i[g*TC_W +: TC_W];
  end

  always_comb begin
    idx_o  = '0;
    code_o = '0;
    for (int i = PORTS-1; i >= 0; i--) begin
      if (rx_valid_i[i]) begin
        idx_o  = IDX_W'(i);
        code_o = codes[i];
      end
    end
  end

  assign any_o = |rx_valid_i;

  // R10: the chosen port is strobing and no lower-numbered port is strobing
  p_lowest_port_r10: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> (rx_valid_i[idx_o] &&
               ((rx_valid_i & ((PORTS'(1) << idx_o) - PORTS'(1))) == '0)));
endmodule

// File: rtl/tc_stretch.sv
module tc_stretch
  import tc_pkg::*;
#(
  parameter int HOLD   = 4,
  parameter int HOLD_W = 3
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   fire_i,
  input  tcode_t code_i,
  output logic   tick_o,
  output tcode_t time_o
);
  logic [HOLD_W-1:0] cnt_q, cnt_d;
  tcode_t            time_q;

  always_comb begin
    cnt_d = cnt_q;
    if (fire_i)            cnt_d = HOLD_W'(HOLD);
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      time_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (fire_i) time_q <= code_i;
    end
  end

  assign tick_o = (cnt_q != '0);
  assign time_o = time_q;

  // R8: the value held during the tick-out changes only when a new code fires
  p_time_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && !fire_i) |=> $stable(time_o));
  // R8: a fire always starts a tick-out of full length
  p_fire_starts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |=> (tick_o && cnt_q == HOLD_W'(HOLD)));
  // R8: without a new fire the hold counter only counts down
  p_countdown_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire_i && tick_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/time_code_ctrl.sv
module time_code_ctrl
  import tc_pkg::*;
#(
  parameter int NUM_PORTS   = 4,
  parameter int SYNC_STAGES = 2,
  parameter int TICK_HOLD   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ext_tick_i,
  input  logic [7:0]                ext_value_i,
  input  logic                      ext_load_i,
  input  logic                      clr_count_i,
  input  logic                      master_mode_i,
  input  logic [NUM_PORTS-1:0]      rx_valid_i,
  input  logic [NUM_PORTS*8-1:0]    rx_code_i,
  output logic [NUM_PORTS-1:0]      tx_valid_o,
  output logic [7:0]                tx_code_o,
  output logic                      ext_tick_o,
  output logic [7:0]                ext_time_o
);
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int HOLD_W = $clog2(TICK_HOLD + 1);

  logic                 tick_rise;
  logic                 sel_any;
  logic [PORT_W-1:0]    sel_idx;
  tcode_t               sel_code;

  tcode_t               time_q, time_d;
  tcode_t               code_q, code_d;
  logic [NUM_PORTS-1:0] tx_q, tx_d;
  logic                 fire;

  tc_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .async_i(ext_tick_i), .rise_o(tick_rise)
  );

  tc_rx_pick #(.PORTS(NUM_PORTS), .IDX_W(PORT_W)) i_pick (
    .clk(clk), .rst_n(rst_n), .rx_valid_i(rx_valid_i), .rx_code_i(rx_code_i),
    .any_o(sel_any), .idx_o(sel_idx), .code_o(sel_code)
  );

  always_comb begin
    time_d = time_q;
    code_d = code_q;
    tx_d   = '0;
    fire   = 1'b0;
    if (clr_count_i) begin
      time_d = '0;
    end else if (master_mode_i) begin
      if (tick_rise) begin
        time_d = ext_load_i ? ext_value_i : tc_advance(time_q);
        code_d = time_d;
        tx_d   = '1;
      end
    end else if (sel_any) begin
      time_d = sel_code;
      if (sel_code == tc_advance(time_q)) begin
        code_d = sel_code;
        tx_d   = ~(NUM_PORTS'(1) << sel_idx);
        fire   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= '0;
      code_q <= '0;
      tx_q   <= '0;
    end else begin
      time_q <= time_d;
      code_q <= code_d;
      tx_q   <= tx_d;
    end
  end

  tc_stretch #(.HOLD(TICK_HOLD), .HOLD_W(HOLD_W)) i_stretch (
    .clk(clk), .rst_n(rst_n), .fire_i(fire), .code_i(sel_code),
    .tick_o(ext_tick_o), .time_o(ext_time_o)
  );

  assign tx_valid_o = tx_q;
  assign tx_code_o  = code_q;

  // R2: a master tick edge reaches every port in the next cycle
  p_master_bcast_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode_i && tick_rise && !clr_count_i) |=> (tx_valid_o == '1));
  // R3: automatic advance never alters the two control bits
  p_ctrl_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode_i && tick_rise && !ext_load_i && !clr_count_i)
      |=> (time_q[7:6] == $past(time_q[7:6])));
  // R6: clear empties the register and blocks sending
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_count_i |=> (time_q == '0 && tx_valid_o == '0));
  // R7: a forwarded code is never echoed to its arrival port
  p_no_echo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode_i && sel_any && !clr_count_i) |=> !tx_valid_o[$past(sel_idx)]);
  // R11: in master mode, nothing but a tick edge causes a send
  p_master_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode_i && !tick_rise) |=> (tx_valid_o == '0));
endmodule

// File: tb/test_time_code_ctrl.sv
module test_time_code_ctrl;
  localparam int NP   = 4;
  localparam int SYNC = 2;
  localparam int HOLD = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ext_tick, ext_load, clr, master;
  logic [7:0]    ext_value;
  logic [NP-1:0] rx_valid;
  logic [NP*8-1:0] rx_code;
  logic [NP-1:0] tx_valid;
  logic [7:0]    tx_code, ext_time;
  logic          ext_tick_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  time_code_ctrl #(.NUM_PORTS(NP), .SYNC_STAGES(SYNC), .TICK_HOLD(HOLD)) i_time_code_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_tick_i(ext_tick), .ext_value_i(ext_value),
    .ext_load_i(ext_load), .clr_count_i(clr), .master_mode_i(master),
    .rx_valid_i(rx_valid), .rx_code_i(rx_code), .tx_valid_o(tx_valid),
    .tx_code_o(tx_code), .ext_tick_o(ext_tick_o), .ext_time_o(ext_time)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Master tick: drive at negedge, the send is due SYNC+1 edges later
  task automatic master_tick(input logic load, input logic [7:0] val,
                             input logic [7:0] exp, input string req);
    @(negedge clk);
    ext_tick = 1'b1; ext_load = load; ext_value = val;
    for (int k = 1; k <= SYNC; k++) begin
      @(negedge clk);
      chk({req, " early"}, 32'(tx_valid), 0);
    end
    @(negedge clk);
    chk({req, " strobes"}, 32'(tx_valid), 32'({NP{1'b1}}));
    chk({req, " code"}, 32'(tx_code), 32'(exp));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R5 single send", 32'(tx_valid), 0);
    end
    ext_tick = 1'b0; ext_load = 1'b0;
    repeat (SYNC + 1) @(negedge clk);
  endtask

  // Receive pulse: drive at negedge, result due one edge later
  task automatic rx_pulse(input logic [NP-1:0] v, input logic [NP*8-1:0] c);
    @(negedge clk);
    rx_valid = v; rx_code = c;
    @(negedge clk);
    rx_valid = '0;
  endtask

  task automatic t_reset;
    chk("R1 tx idle", 32'(tx_valid), 0);
    chk("R1 tick-out low", 32'(ext_tick_o), 0);
    chk("R1 time zero", 32'(ext_time), 0);
  endtask

  task automatic t_master_seq;
    master_tick(1'b0, 8'h00, 8'h01, "R1/R2 first auto");
    master_tick(1'b0, 8'h00, 8'h02, "R2 auto");
    master_tick(1'b1, 8'hBE, 8'hBE, "R4 load");
    master_tick(1'b0, 8'h00, 8'hBF, "R2 auto upper");
    master_tick(1'b0, 8'h00, 8'h80, "R3 wrap");
  endtask

  task automatic t_clear;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    chk("R6 no send on clear", 32'(tx_valid), 0);
    master_tick(1'b0, 8'h00, 8'h01, "R6 after clear");
  endtask

  task automatic t_master_ignores_rx;
    rx_pulse(4'b0001, {24'h0, 8'h02});
    chk("R11 rx ignored in master", 32'(tx_valid), 0);
    chk("R11 no tick-out in master", 32'(ext_tick_o), 0);
    master_tick(1'b0, 8'h00, 8'h02, "R11 register kept");
  endtask

  task automatic t_slave_forward;
    master = 1'b0;
    rx_pulse(4'b0010, {16'h0, 8'h03, 8'h0});
    chk("R7 forward mask", 32'(tx_valid), 32'(4'b1101));
    chk("R7 forward code", 32'(tx_code), 32'h03);
    for (int k = 1; k <= HOLD; k++) begin
      chk("R8 tick-out high", 32'(ext_tick_o), 1);
      chk("R8 time value", 32'(ext_time), 32'h03);
      @(negedge clk);
      if (k == 1) chk("R7 one-cycle strobe", 32'(tx_valid), 0);
    end
    chk("R8 tick-out falls", 32'(ext_tick_o), 0);
  endtask

  task automatic t_slave_mismatch;
    rx_pulse(4'b0100, {8'h0, 8'h10, 16'h0});
    chk("R9 no forward", 32'(tx_valid), 0);
    chk("R9 no tick-out", 32'(ext_tick_o), 0);
    rx_pulse(4'b0001, {24'h0, 8'h11});
    chk("R9 register loaded", 32'(tx_valid), 32'(4'b1110));
    chk("R9 code", 32'(tx_code), 32'h11);
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic t_multi_port;
    rx_pulse(4'b1010, {8'h55, 8'h0, 8'h12, 8'h0});
    chk("R10 lowest port wins", 32'(tx_valid), 32'(4'b1101));
    chk("R10 code", 32'(tx_code), 32'h12);
    repeat (HOLD) @(negedge clk);
    rx_pulse(4'b0101, {8'h0, 8'h13, 8'h0, 8'h40});
    chk("R10 low port mismatch taken", 32'(tx_valid), 0);
    rx_pulse(4'b1000, {8'h41, 24'h0});
    chk("R10 register from port 0", 32'(tx_valid), 32'(4'b0111));
    chk("R10 code 41", 32'(tx_code), 32'h41);
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic t_slave_ignores_tick;
    @(negedge clk); ext_tick = 1'b1;
    for (int k = 0; k < SYNC + 3; k++) begin
      @(negedge clk);
      chk("R11 tick ignored in slave", 32'(tx_valid), 0);
    end
    ext_tick = 1'b0;
    rx_pulse(4'b0001, {24'h0, 8'h42});
    chk("R11 slave register kept", 32'(tx_valid), 32'(4'b1110));
    repeat (HOLD) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; ext_tick = 1'b0; ext_load = 1'b0; ext_value = '0;
    clr = 1'b0; master = 1'b1; rx_valid = '0; rx_code = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_master_seq();
    t_clear();
    t_master_ignores_rx();
    t_slave_forward();
    t_slave_mismatch();
    t_multi_port();
    t_slave_ignores_tick();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule